// File: doc/BRIEF.md
# Shared-Prescale Serial Clock Divider

This block produces the serial clock and a bit-rate strobe for one transfer format of a master-mode serial peripheral. It divides the peripheral clock by a programmable ratio. The ratio is held in a single 11-bit storage word. Software can reach that word through two register views of different widths. The wide view at address 1 exposes all 11 bits. The narrow view sits in bits 15:8 of the format register at address 0 and exposes only the low 8 bits.

A write through the narrow view also zeroes the three upper storage bits. This means a ratio above 256 survives only if the wide view is written last. The divider runs only while the block is the master and transfers are enabled; otherwise the clock stays at its idle level. A new ratio is taken into the running counter only at a period boundary, or while the divider is idle. As a result, a write during a period never shortens a clock phase.

Top module: `spi_clkgen_alias`

## Requirements
- R1: After reset the stored prescale and the other format bits are zero, both register views read zero, the serial clock is at its idle level (low by default) and the bit tick is low.
- R2: A write to address 1 stores wdata[10:0] as the prescale (0 to 2047). A read of address 1 returns the prescale in bits 10:0 and zero above.
- R3: Bits 15:8 of the address-0 read always equal prescale bits 7:0, whichever view was written last.
- R4: A write to address 0 sets the prescale to {3'b000, wdata[15:8]}, discarding any upper bits set earlier through address 1.
- R5: While running with prescale P, the bit tick is high for exactly one cycle in every P+1 cycles. The first tick falls in the (P+1)th running cycle, and with P=0 the tick is high every cycle.
- R6: In each period of P+1 cycles, the serial clock sits at idle level for the first floor((P+1)/2) cycles and at the opposite level for the rest. With P=0 it stays at the opposite level.
- R7: One cycle after the master input or the transfer enable goes low, the serial clock returns to idle level and the tick stays low, whatever the prescale holds.
- R8: A prescale written while a period is in progress leaves that period's length and phases unchanged and applies from the next period on.
- R9: A write to address 0 stores every bit outside 15:8, and an address-0 read returns those bits unchanged.
- R10: Writes to any address other than 0 and 1 change no stored state, and reads of such addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register address for reads and writes |
| wdata | input | DATA_W | Write data |
| we | input | 1 | Write strobe |
| rdata | output | DATA_W | Read data for the addressed register (combinational) |
| master | input | 1 | 1 selects master mode; 0 is slave mode |
| xfer_en | input | 1 | Transfer enable |
| sclk | output | 1 | Divided serial clock |
| bit_tick | output | 1 | One-cycle pulse at the end of each bit period |

## Verification
The hardest condition to reach is a ratio change that lands partway through a running period. That change has to be held off until the wrap, and this matters most when it moves the ratio from a small value to a large one or back. The stimulus writes both views at arbitrary cycles while the divider runs. Each write is placed some cycles after a tick. A behavioural model predicts every clock and tick cycle, and gap counts between ticks confirm the old period finishes before the new one starts. The ordering rule for ratios above 256 is covered by writing the wide view and then the narrow view while running, and checking that the tick gap collapses to the 8-bit ratio.

// File: rtl/spi_cg_pkg.sv
`timescale 1ns/1ps
package spi_cg_pkg;
   localparam int unsigned FMT_ADDR = 0;
   localparam int unsigned EXT_ADDR = 1;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_FMT  = 2'd1,
      SEL_EXT  = 2'd2
   } reg_sel_e;
endpackage

// File: rtl/spi_cg_regs.sv
`timescale 1ns/1ps
module spi_cg_regs
   import spi_cg_pkg::*;
#(
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 32,
   parameter int PRE_W   = 11,
   parameter int LEG_W   = 8,
   parameter int LEG_LSB = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              we,
   output logic [DATA_W-1:0] rdata,
   output logic [PRE_W-1:0]  pre_q
);
   localparam logic [DATA_W-1:0] LEG_MASK =
      {{(DATA_W-LEG_W){1'b0}}, {LEG_W{1'b1}}} << LEG_LSB;

   generate
      if (PRE_W < LEG_W) begin : g_bad_width
         $error("wide prescale view narrower than legacy view");
      end
      if (LEG_LSB + LEG_W > DATA_W) begin : g_bad_pos
         $error("legacy field outside data word");
      end
      if (PRE_W > DATA_W) begin : g_bad_pre
         $error("prescale wider than data word");
      end
   endgenerate

   reg_sel_e           sel;
   logic [DATA_W-1:0]  fmt_q;

   always_comb begin
      if (addr == ADDR_W'(FMT_ADDR))      sel = SEL_FMT;
      else if (addr == ADDR_W'(EXT_ADDR)) sel = SEL_EXT;
      else                                sel = SEL_NONE;
   end

   // One storage word; the legacy view zero-extends into it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         fmt_q <= '0;
      end else if (we) begin
         case (sel)
            SEL_FMT: begin
               pre_q <= PRE_W'(wdata[LEG_LSB +: LEG_W]);
               fmt_q <= wdata & ~LEG_MASK;
            end
            SEL_EXT: pre_q <= wdata[PRE_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      case (sel)
         SEL_FMT: rdata = fmt_q | (DATA_W'(pre_q[LEG_W-1:0]) << LEG_LSB);
         SEL_EXT: rdata = DATA_W'(pre_q);
         default: rdata = '0;
      endcase
   end

   assert_legacy_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == SEL_FMT) |=>
         pre_q == PRE_W'($past(wdata[LEG_LSB +: LEG_W])));

   assert_wide_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == SEL_EXT) |=> pre_q == $past(wdata[PRE_W-1:0]));

   assert_other_addr_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == SEL_NONE) |=> ($stable(pre_q) && $stable(fmt_q)));
endmodule

// File: rtl/spi_cg_divider.sv
`timescale 1ns/1ps
module spi_cg_divider #(
   parameter int PRE_W     = 11,
   parameter bit IDLE_HIGH = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_req,
   input  logic [PRE_W-1:0] pre_in,
   output logic             sclk,
   output logic             tick
);
   logic             run_q;
   logic [PRE_W-1:0] cnt_q;
   logic [PRE_W-1:0] act_q;
   logic [PRE_W:0]   half;
   logic             wrap;
   logic             hi_phase;

   assign wrap     = (cnt_q == act_q);
   assign half     = ({1'b0, act_q} + 1'b1) >> 1;
   assign hi_phase = ({1'b0, cnt_q} >= half);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
         act_q <= '0;
      end else if (!run_req) begin
         run_q <= 1'b0;
         cnt_q <= '0;
         act_q <= pre_in;
      end else if (!run_q) begin
         run_q <= 1'b1;
         cnt_q <= '0;
         act_q <= pre_in;
      end else if (wrap) begin
         cnt_q <= '0;
         act_q <= pre_in;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick = run_q & wrap;

   generate
      if (IDLE_HIGH) begin : g_idle_hi
         assign sclk = ~(run_q & hi_phase);
      end else begin : g_idle_lo
         assign sclk = run_q & hi_phase;
      end
   endgenerate

   assert_count_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> cnt_q <= act_q);

   assert_ratio_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && $past(run_q) && $past(run_req) && !$past(wrap)) |-> $stable(act_q));
endmodule

// File: rtl/spi_clkgen_alias.sv
`timescale 1ns/1ps
module spi_clkgen_alias #(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 32,
   parameter int PRE_W     = 11,
   parameter int LEG_W     = 8,
   parameter int LEG_LSB   = 8,
   parameter bit IDLE_HIGH = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              we,
   output logic [DATA_W-1:0] rdata,
   input  logic              master,
   input  logic              xfer_en,
   output logic              sclk,
   output logic              bit_tick
);
   logic [PRE_W-1:0] pre;
   logic             run_req;

   assign run_req = master & xfer_en;

   spi_cg_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_W(PRE_W),
      .LEG_W(LEG_W), .LEG_LSB(LEG_LSB)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
      .we(we), .rdata(rdata), .pre_q(pre)
   );

   spi_cg_divider #(
      .PRE_W(PRE_W), .IDLE_HIGH(IDLE_HIGH)
   ) u_div (
      .clk(clk), .rst_n(rst_n), .run_req(run_req), .pre_in(pre),
      .sclk(sclk), .tick(bit_tick)
   );

   assert_idle_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(master && xfer_en) |=> (sclk == IDLE_HIGH && !bit_tick));

   assert_zero_ratio_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(master && xfer_en) && master && xfer_en && pre == '0
       && $past(pre) == '0) |=> bit_tick);
endmodule

// File: tb/spi_clkgen_alias_bench.sv
`timescale 1ns/1ps
module spi_clkgen_alias_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        we = 1'b0;
   logic [31:0] rdata;
   logic        master = 1'b0;
   logic        xfer_en = 1'b0;
   logic        sclk;
   logic        bit_tick;

   int checks = 0;
   int failures = 0;

   // behavioural reference state
   int m_store = 0;
   int m_fmt = 0;
   bit m_run = 0;
   int m_ph = 0;
   int m_div = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_clkgen_alias u_spi_clkgen_alias (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
      .rdata(rdata), .master(master), .xfer_en(xfer_en),
      .sclk(sclk), .bit_tick(bit_tick)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_store = 0; m_fmt = 0; m_run = 0; m_ph = 0; m_div = 0;
      end else begin
         if (!(master && xfer_en)) begin
            m_run = 0; m_ph = 0; m_div = m_store;
         end else if (!m_run) begin
            m_run = 1; m_ph = 0; m_div = m_store;
         end else if (m_ph == m_div) begin
            m_ph = 0; m_div = m_store;
         end else begin
            m_ph = m_ph + 1;
         end
         if (we && addr == 4'd0) begin
            m_store = (wdata >> 8) & 32'hFF;
            m_fmt = wdata & 32'hFFFF_00FF;
         end else if (we && addr == 4'd1) begin
            m_store = wdata & 32'h7FF;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] exp_rd();
      if (addr == 4'd0) return m_fmt | ((m_store & 32'hFF) << 8);
      if (addr == 4'd1) return m_store;
      return 32'h0;
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R5 bit_tick", {31'b0, bit_tick}, {31'b0, m_run && m_ph == m_div});
         chk("R6/R7 sclk", {31'b0, sclk}, {31'b0, m_run && m_ph >= (m_div + 1) / 2});
         chk("R3/R9/R10 rdata", rdata, exp_rd());
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      addr = a; wdata = d; we = 1'b1;
      @(posedge clk); #1;
      we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
      @(posedge clk); #1;
      addr = a; we = 1'b0;
      @(negedge clk);
      chk(tag, rdata, exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic gap(input int exp, input string tag);
      int n = 0;
      do @(negedge clk); while (bit_tick !== 1'b1);
      do begin @(negedge clk); n++; end while (bit_tick !== 1'b1 && n < 5000);
      chk(tag, n, exp);
   endtask

   initial begin
      idle(3);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 sclk", {31'b0, sclk}, 32'd0);
      chk("R1 tick", {31'b0, bit_tick}, 32'd0);
      rd(4'd0, 32'h0, "R1 fmt view");
      rd(4'd1, 32'h0, "R1 wide view");

      // R2/R3 wide write visible through both views
      wr(4'd1, 32'hFFFF_F805);
      rd(4'd1, 32'h0000_0005, "R2 wide read");
      rd(4'd0, 32'h0000_0500, "R3 alias read");
      master = 1'b1; xfer_en = 1'b1;
      gap(6, "R5 gap P=5");
      idle(20);

      // R4/R9 legacy write with other bits
      wr(4'd0, 32'hA5A5_3C5A);
      rd(4'd0, 32'hA5A5_3C5A, "R9 fmt other bits");
      rd(4'd1, 32'h0000_003C, "R4 wide after legacy");
      idle(130);

      // R4 ordering: wide then legacy cancels upper bits
      wr(4'd1, 32'h0000_07FF);
      gap(2048, "R2 gap P=2047");
      wr(4'd0, 32'h0000_1200);
      rd(4'd1, 32'h0000_0012, "R4 upper cleared");
      rd(4'd0, 32'h0000_1200, "R3 legacy read");
      idle(2100);
      gap(19, "R4 gap P=18");

      // R8 mid-period change
      wr(4'd1, 32'd9);
      gap(10, "R8 gap P=9");
      repeat (4) @(negedge clk);
      wr(4'd1, 32'd2);
      gap(3, "R8 new ratio next period");
      idle(15);

      // R5/R6 edge ratios
      wr(4'd1, 32'd0);
      idle(4);
      gap(1, "R5 gap P=0");
      wr(4'd1, 32'd1);
      idle(10);

      // R7 slave and disable
      master = 1'b0;
      idle(2);
      @(negedge clk);
      chk("R7 slave sclk", {31'b0, sclk}, 32'd0);
      chk("R7 slave tick", {31'b0, bit_tick}, 32'd0);
      wr(4'd1, 32'd4);
      idle(10);
      master = 1'b1;
      idle(20);
      xfer_en = 1'b0;
      idle(5);
      xfer_en = 1'b1;
      idle(12);

      // R10 other addresses
      wr(4'd2, 32'hFFFF_FFFF);
      wr(4'd15, 32'h0000_0300);
      rd(4'd2, 32'h0, "R10 read other");
      rd(4'd1, 32'd4, "R10 store kept");
      rd(4'd0, 32'h0000_0400, "R10 fmt kept");
      idle(20);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule